// File: doc/BRIEF.md
# Packed-Byte Media ALU

This block is a single-slot SIMD execution unit for pixel-oriented work on 64-bit registers. Each accepted operation takes an opcode and two source operands, Ra and Rb. One clock later it returns a 64-bit result with a valid strobe. The operations are:

- byte widening into 16-bit or 32-bit lanes;
- truncating narrowing of 16-bit or 32-bit lanes down to bytes;
- lane-wise minimum and maximum, in signed or unsigned form, over eight byte lanes or four 16-bit lanes;
- a pixel-error reduction that sums the absolute differences of the eight byte pairs.

The unit sits behind instruction decode and in front of register writeback. It has no internal state apart from the output register, so a new operation can be issued on every cycle.

Top module: `media_alu`

## Requirements
- R1: While rst_ni is low, and after it is released, valid_o and result_o read zero until the first operation is accepted.
- R2: When valid_i is high at a rising clock edge, valid_o is high after that edge and result_o carries the operation's result. When valid_i is low, valid_o is low after the edge and result_o keeps its previous value.
- R3: Opcode 0 (byte-to-word widen): result lane k (bits 16k+15:16k, k=0..3) equals Ra byte k, zero-extended.
- R4: Opcode 1 (byte-to-longword widen): result lane k (bits 32k+31:32k, k=0..1) equals Ra byte k, zero-extended.
- R5: Opcode 2 (word-to-byte narrow): result byte k (k=0..3) equals the low byte of Ra 16-bit lane k, and result bits 63:32 are zero.
- R6: Opcode 3 (longword-to-byte narrow): result byte k (k=0..1) equals the low byte of Ra 32-bit lane k, and result bits 63:16 are zero.
- R7: Unsigned min/max compare lanes as magnitudes. The opcodes are 4 (byte min), 5 (word min), 8 (byte max) and 9 (word max).
- R8: Signed min/max compare lanes as two's complement. The opcodes are 6 (byte min), 7 (word min), 10 (byte max) and 11 (word max).
- R9: In every min/max form, each result lane equals the Ra lane or the Rb lane, and a pair of equal lanes returns that value.
- R10: Opcode 12 (pixel error): the result equals the sum of |Ra byte i − Rb byte i| over i=0..7. The sum is right-aligned, with result bits 63:11 zero.
- R11: The widen and narrow opcodes (0 to 3) ignore Rb.
- R12: Opcodes 13 to 15 produce a zero result, with valid_o still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation accepted at this edge |
| op_i | input | 4 | Opcode |
| ra_i | input | 64 | First source operand |
| rb_i | input | 64 | Second source operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Registered result |

## Verification
The assertions assume that valid_i, op_i, ra_i and rb_i are stable and known at every rising edge while rst_ni is high. They also assume that reset is applied before the first operation. The stimulus changes inputs only on falling edges and holds valid_i low throughout reset. It issues all sixteen opcodes, including the undefined ones, with operands chosen to hit sign boundaries, equal lanes and the largest pixel-error sum. Between bursts it leaves idle cycles, so that hold behaviour is also exercised.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;
  typedef enum logic [3:0] {
    OP_WIDEN_BW  = 4'd0,
    OP_WIDEN_BL  = 4'd1,
    OP_NARROW_WB = 4'd2,
    OP_NARROW_LB = 4'd3,
    OP_MIN_UB    = 4'd4,
    OP_MIN_UW    = 4'd5,
    OP_MIN_SB    = 4'd6,
    OP_MIN_SW    = 4'd7,
    OP_MAX_UB    = 4'd8,
    OP_MAX_UW    = 4'd9,
    OP_MAX_SB    = 4'd10,
    OP_MAX_SW    = 4'd11,
    OP_PIX_ERR   = 4'd12
  } op_e;
endpackage

// File: rtl/mm_lane_shuffle.sv
module mm_lane_shuffle
  import media_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src_i,
  input  op_e             op_i,
  output logic [XLEN-1:0] y_o
);
  localparam int W_LANES = XLEN / 16;
  localparam int L_LANES = XLEN / 32;

  always_comb begin
    y_o = '0;
    unique case (op_i)
      OP_WIDEN_BW: for (int i = 0; i < W_LANES; i++) y_o[16*i +: 16] = {8'h00, src_i[8*i +: 8]};
      OP_WIDEN_BL: for (int i = 0; i < L_LANES; i++) y_o[32*i +: 32] = {24'h0, src_i[8*i +: 8]};
      OP_NARROW_WB: for (int i = 0; i < W_LANES; i++) y_o[8*i +: 8] = src_i[16*i +: 8];
      OP_NARROW_LB: for (int i = 0; i < L_LANES; i++) y_o[8*i +: 8] = src_i[32*i +: 8];
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mm_lane_minmax.sv
module mm_lane_minmax #(
  parameter int XLEN   = 64,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sgn_i,
  input  logic            max_i,
  output logic [XLEN-1:0] y_o
);
  localparam int N_LANES = XLEN / LANE_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    logic a_lt_b, pick_a;
    assign la     = a_i[LANE_W*g +: LANE_W];
    assign lb     = b_i[LANE_W*g +: LANE_W];
    assign a_lt_b = sgn_i ? ($signed(la) < $signed(lb)) : (la < lb);
    assign pick_a = max_i ? !a_lt_b : a_lt_b;
    assign y_o[LANE_W*g +: LANE_W] = pick_a ? la : lb;
  end
endmodule

// File: rtl/mm_pix_err.sv
module mm_pix_err #(
  parameter int XLEN  = 64,
  parameter int SUM_W = 11
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam int NB = XLEN / 8;

  logic [7:0] diff [NB];

  for (genvar g = 0; g < NB; g++) begin : g_abs
    logic [7:0] x, y;
    assign x = a_i[8*g +: 8];
    assign y = b_i[8*g +: 8];
    assign diff[g] = (x > y) ? (x - y) : (y - x);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NB; i++) sum_o = sum_o + SUM_W'(diff[i]);
  end
endmodule

// File: rtl/media_alu.sv
module media_alu
  import media_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] ra_i,
  input  logic [XLEN-1:0] rb_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o
);
  localparam int NB    = XLEN / 8;
  localparam int SUM_W = 8 + $clog2(NB + 1);

  op_e op;
  assign op = op_e'(op_i);

  logic [XLEN-1:0] shuf_y, mm_b_y, mm_w_y, res_d, res_q;
  logic [SUM_W-1:0] pe_sum;
  logic b_sgn, b_max, w_sgn, w_max, valid_q;

  assign b_sgn = (op == OP_MIN_SB) || (op == OP_MAX_SB);
  assign b_max = (op == OP_MAX_UB) || (op == OP_MAX_SB);
  assign w_sgn = (op == OP_MIN_SW) || (op == OP_MAX_SW);
  assign w_max = (op == OP_MAX_UW) || (op == OP_MAX_SW);

  // Rb never reaches the shuffle path
  mm_lane_shuffle #(.XLEN(XLEN)) u_shuf (.src_i(ra_i), .op_i(op), .y_o(shuf_y));

  mm_lane_minmax #(.XLEN(XLEN), .LANE_W(8)) u_mm_b (
    .a_i(ra_i), .b_i(rb_i), .sgn_i(b_sgn), .max_i(b_max), .y_o(mm_b_y));

  mm_lane_minmax #(.XLEN(XLEN), .LANE_W(16)) u_mm_w (
    .a_i(ra_i), .b_i(rb_i), .sgn_i(w_sgn), .max_i(w_max), .y_o(mm_w_y));

  mm_pix_err #(.XLEN(XLEN), .SUM_W(SUM_W)) u_pe (.a_i(ra_i), .b_i(rb_i), .sum_o(pe_sum));

  always_comb begin
    unique case (op)
      OP_WIDEN_BW, OP_WIDEN_BL, OP_NARROW_WB, OP_NARROW_LB: res_d = shuf_y;
      OP_MIN_UB, OP_MIN_SB, OP_MAX_UB, OP_MAX_SB:           res_d = mm_b_y;
      OP_MIN_UW, OP_MIN_SW, OP_MAX_UW, OP_MAX_SW:           res_d = mm_w_y;
      OP_PIX_ERR: res_d = {{(XLEN-SUM_W){1'b0}}, pe_sum};
      default:    res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |=> (!valid_o && result_o == '0));
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);
  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
  a_r5_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd2) |=> result_o[XLEN-1:32] == '0);
  a_r6_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd3) |=> result_o[XLEN-1:16] == '0);
  a_r9_byte_lane_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 4'd4 && op_i <= 4'd11) |=>
      (result_o[7:0] == $past(ra_i[7:0]) || result_o[7:0] == $past(rb_i[7:0])));
  a_r10_sum_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd12) |=> result_o[XLEN-1:SUM_W] == '0);
  a_r12_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd12) |=> (valid_o && result_o == '0));
endmodule

// File: tb/media_alu_test.sv
module media_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [63:0] ra = '0, rb = '0;
  logic        valid_o;
  logic [63:0] result_o;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [63:0] last_res = '0;

  always #5 clk = ~clk;

  media_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .ra_i(ra), .rb_i(rb), .valid_o(valid_o), .result_o(result_o));

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5, 4'd8, 4'd9: return "R7";
      4'd6, 4'd7, 4'd10, 4'd11: return "R8";
      4'd12: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int w, s, acc;
    bit is_max, is_sgn, take_a;
    case (o)
      4'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(a[8*i +: 8]);
      4'd1: for (int i = 0; i < 2; i++) r[32*i +: 32] = 32'(a[8*i +: 8]);
      4'd2: for (int i = 0; i < 4; i++) r[8*i +: 8] = a[16*i +: 8];
      4'd3: for (int i = 0; i < 2; i++) r[8*i +: 8] = a[32*i +: 8];
      4'd12: begin
        acc = 0;
        for (int i = 0; i < 8; i++) begin
          s = int'(a[8*i +: 8]) - int'(b[8*i +: 8]);
          acc += (s < 0) ? -s : s;
        end
        r = 64'(acc);
      end
      default: if (o >= 4'd4 && o <= 4'd11) begin
        w      = o[0] ? 16 : 8;
        is_sgn = o[1];
        is_max = o[3];
        for (int i = 0; i < 64 / w; i++) begin
          int x, y;
          if (w == 8) begin
            x = is_sgn ? int'($signed(a[8*i +: 8])) : int'(a[8*i +: 8]);
            y = is_sgn ? int'($signed(b[8*i +: 8])) : int'(b[8*i +: 8]);
          end else begin
            x = is_sgn ? int'($signed(a[16*i +: 16])) : int'(a[16*i +: 16]);
            y = is_sgn ? int'($signed(b[16*i +: 16])) : int'(b[16*i +: 16]);
          end
          take_a = is_max ? (x >= y) : (x <= y);
          if (w == 8) r[8*i +: 8] = take_a ? a[8*i +: 8] : b[8*i +: 8];
          else        r[16*i +: 16] = take_a ? a[16*i +: 16] : b[16*i +: 16];
        end
      end
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic v_exp, input logic [63:0] r_exp);
    total++;
    if (valid_o !== v_exp || result_o !== r_exp) begin
      bad++;
      $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
               req, valid_o, result_o, v_exp, r_exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b);
    valid = 1'b1; op = o; ra = a; rb = b;
    @(negedge clk);
    last_res = model(o, a, b);
    check(tag(o), 1'b1, last_res);
    valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      op = 4'($urandom); ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      @(negedge clk);
      check("R2", 1'b0, last_res);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 64'd0);

    // widen/narrow, with Rb varied to show it is ignored (R11)
    for (int o = 0; o < 4; o++) begin
      issue(4'(o), 64'h8877_6655_4433_2211, 64'd0);
      issue(4'(o), 64'h8877_6655_4433_2211, 64'hFFFF_FFFF_FFFF_FFFF);
      if (result_o !== model(4'(o), 64'h8877_6655_4433_2211, 64'd0)) begin
        bad++; $display("FAIL R11: result=%h", result_o);
      end
      total++;
    end
    idle(2);
    // sign boundary for min/max R7 R8
    for (int o = 4; o < 12; o++) begin
      issue(4'(o), 64'h7F80_0001_FF00_8000, 64'h807F_FF01_00FF_7FFF);
      issue(4'(o), 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0); // R9 equal lanes
    end
    idle(1);
    issue(4'd12, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF); // R10 maximum 2040
    issue(4'd12, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201);
    for (int o = 13; o < 16; o++) issue(4'(o), 64'hDEAD_BEEF_0BAD_F00D, 64'h1);
    idle(3);
    for (int k = 0; k < 200; k++) begin
      issue(4'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
      if (k % 7 == 0) idle(1);
    end
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule